// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two WIDTH-bit operands one bit position per clock, using a single full-adder cell and a one-bit carry register in place of a chain of WIDTH full adders. Both operands are first loaded in parallel into two right-shifting registers, the accumulator and the addend. A start pulse then runs exactly WIDTH shift cycles. In each of these cycles the low bits of the two registers and the stored carry are added. The resulting sum bit enters the top of the accumulator as it shifts right.

When the run ends, the accumulator holds the WIDTH-bit sum and the carry register holds the carry out of the top bit. A one-cycle done pulse marks the end of the run. The carry register behaves as a JK flip-flop. It is set when both operand bits are 1, cleared when both are 0, and left unchanged when exactly one of them is 1. This is the same as taking the full-adder carry-out.

A parameter chooses what enters the top of the addend register: zeros, or its own low bit (recirculation). Starting a new run without a fresh load adds the addend to the previous sum, and the carry left from the previous run serves as the carry-in. This lets wider words be chained.

Top module: `bsa_serial_adder`

## Requirements
- R1: After reset the accumulator, the addend register, the carry and the counter are 0. A load pulse while idle copies opa_i into the accumulator and opb_i into the addend register and clears the carry; acc_o, opb_o and carry_o show these values on the following cycle.
- R2: A start pulse while idle, with load low, makes busy_o go high on the next cycle. busy_o then stays high for exactly WIDTH cycles.
- R3: In every busy cycle the accumulator shifts right by one, and bit WIDTH-1 takes acc[0] XOR opb[0] XOR carry.
- R4: In every busy cycle the carry is set when acc[0] and opb[0] are both 1, cleared when both are 0, and unchanged otherwise.
- R5: When a run that started from a fresh load ends, acc_o equals (A+B) mod 2^WIDTH and carry_o equals bit WIDTH of A+B.
- R6: done_o is high for exactly one cycle. That cycle is the first cycle with busy_o low after the run, and it comes WIDTH+1 cycles after the cycle in which start was applied. While idle, with no load, all registers hold their values.
- R7: With the default fill (zero), opb_o shifts in a 0 at bit WIDTH-1 on each busy cycle and reads 0 after a run.
- R8: Load and start pulses applied while busy_o is high are ignored. The run completes with the result of the operands it began with.
- R9: When load and start are high in the same idle cycle, the load takes effect and the start is ignored.
- R10: A start without a fresh load adds the current addend to the current accumulator, with the retained carry as carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Parallel load of both operands, clears the carry |
| opa_i | input | WIDTH | Operand loaded into the accumulator |
| opb_i | input | WIDTH | Operand loaded into the addend register |
| start_i | input | 1 | Begin a WIDTH-cycle serial addition |
| busy_o | output | 1 | Shift cycles in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| acc_o | output | WIDTH | Accumulator contents, the sum after a run |
| opb_o | output | WIDTH | Addend register contents |
| carry_o | output | 1 | Carry register, the final carry-out after a run |

## Verification
The hardest situations to reach are the ones where a control input arrives at an awkward time. One is a load or start that arrives while a run is still shifting. Another is a start that arrives with no reload after a run that ended with carry set. The bench places load and start pulses a few cycles into a run and checks that the final sum belongs to the original operands. It also follows an all-ones plus one addition with a bare start, so the retained carry becomes the carry-in. A behavioural model tracks every register cycle by cycle. Operand pairs with long carry chains, with no carries at all, and with only the top bit set exercise all three JK cases.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  // What enters the top of the addend register while shifting
  typedef enum logic {
    FILL_ZERO   = 1'b0,
    FILL_RECIRC = 1'b1
  } bsa_fill_e;
endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             shift_i,
  input  logic             sin_i,
  output logic             lsb_o,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_d;
  logic             data_en;

  assign data_en = load_i | shift_i;

  always_comb begin
    data_d = data_q;
    if (load_i)       data_d = par_i;
    else if (shift_i) data_d = {sin_i, data_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign lsb_o = data_q[0];
  assign q_o   = data_q;

  assert_load_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (data_q == $past(par_i)));

  assert_shift_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (data_q[WIDTH-2:0] == $past(data_q[WIDTH-1:1]))
                             && (data_q[WIDTH-1] == $past(sin_i)));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !load_i) |=> $stable(data_q));
endmodule

// File: rtl/bsa_carry_cell.sv
module bsa_carry_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  input  logic x_i,
  input  logic y_i,
  output logic sum_o,
  output logic carry_o
);
  logic cy_q;
  logic cy_d;
  logic cy_en;
  logic jin;
  logic kin;

  assign jin   = x_i & y_i;
  assign kin   = ~x_i & ~y_i;
  assign cy_en = clear_i | step_i;

  always_comb begin
    cy_d = cy_q;
    if (clear_i) begin
      cy_d = 1'b0;
    end else begin
      case ({jin, kin})
        2'b10:   cy_d = 1'b1;
        2'b01:   cy_d = 1'b0;
        2'b11:   cy_d = ~cy_q;
        default: cy_d = cy_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cy_q <= 1'b0;
    else if (cy_en) cy_q <= cy_d;
  end

  assign sum_o   = x_i ^ y_i ^ cy_q;
  assign carry_o = cy_q;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !carry_o);

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && x_i && y_i) |=> carry_o);

  assert_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && !x_i && !y_i) |=> !carry_o);

  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && (x_i ^ y_i)) |=> $stable(carry_o));
endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic start_i,
  output logic load_ok_o,
  output logic shift_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             done_q;
  logic             done_d;
  logic             busy;
  logic             go;

  assign busy      = (cnt_q != '0);
  assign load_ok_o = load_i & ~busy;
  assign go        = start_i & ~load_i & ~busy;
  assign cnt_en    = go | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (go)        cnt_d = CNT_FULL;
    else if (busy) cnt_d = cnt_q - CNT_ONE;
  end

  assign done_d = busy && (cnt_q == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign shift_o = busy;
  assign busy_o  = busy;
  assign done_o  = done_q;

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !load_i && !busy_o) |=> busy_o);

  assert_load_blocks_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> !busy_o);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));
endmodule

// File: rtl/bsa_serial_adder.sv
module bsa_serial_adder #(
  parameter int              WIDTH = 8,
  parameter bsa_pkg::bsa_fill_e FILL = bsa_pkg::FILL_ZERO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] opb_o,
  output logic             carry_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load_ok;
  logic       shift_en;
  logic       a_lsb;
  logic       b_lsb;
  logic       b_sin;
  logic       sum_bit;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bsa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (load_i),
    .start_i   (start_i),
    .load_ok_o (load_ok),
    .shift_o   (shift_en),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  bsa_shreg #(.WIDTH(WIDTH)) u_acc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (load_ok),
    .par_i   (opa_i),
    .shift_i (shift_en),
    .sin_i   (sum_bit),
    .lsb_o   (a_lsb),
    .q_o     (acc_o)
  );

  generate
    if (FILL == bsa_pkg::FILL_RECIRC) begin : g_fill_recirc
      assign b_sin = b_lsb;
    end else begin : g_fill_zero
      assign b_sin = 1'b0;
    end
  endgenerate

  bsa_shreg #(.WIDTH(WIDTH)) u_addend (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (load_ok),
    .par_i   (opb_i),
    .shift_i (shift_en),
    .sin_i   (b_sin),
    .lsb_o   (b_lsb),
    .q_o     (opb_o)
  );

  bsa_carry_cell u_carry (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear_i (load_ok),
    .step_i  (shift_en),
    .x_i     (a_lsb),
    .y_i     (b_lsb),
    .sum_o   (sum_bit),
    .carry_o (carry_o)
  );

  assert_busy_ignores_load_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && load_i) |=> (acc_o[WIDTH-2:0] == $past(acc_o[WIDTH-1:1])));
endmodule

// File: tb/bsa_serial_adder_tb.sv
module bsa_serial_adder_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic         busy_o, done_o, carry_o;
  logic [W-1:0] acc_o, opb_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  bit cmp_on = 0;

  // Reference state
  logic [W-1:0] ma, mb;
  logic         mc, mdone;
  int           mcnt;

  always #5 clk = ~clk;

  bsa_serial_adder #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .opa_i(opa_i), .opb_i(opb_i),
    .start_i(start_i), .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o),
    .opb_o(opb_o), .carry_o(carry_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma = '0; mb = '0; mc = 1'b0; mdone = 1'b0; mcnt = 0;
    end else if (mcnt != 0) begin
      logic x, y, s;
      x = ma[0]; y = mb[0];
      s = x ^ y ^ mc;
      mc = ((32'(x) + 32'(y) + 32'(mc)) >= 2);
      ma = {s, ma[W-1:1]};
      mb = {1'b0, mb[W-1:1]};
      mdone = (mcnt == 1);
      mcnt = mcnt - 1;
    end else begin
      mdone = 1'b0;
      if (load_i) begin
        ma = opa_i; mb = opb_i; mc = 1'b0;
      end else if (start_i) begin
        mcnt = W;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R3 acc per cycle", int'(acc_o), int'(ma));
      chk("R7 addend per cycle", int'(opb_o), int'(mb));
      chk("R4 carry per cycle", int'(carry_o), int'(mc));
      chk("R2 busy per cycle", int'(busy_o), int'(mcnt != 0));
      chk("R6 done per cycle", int'(done_o), int'(mdone));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); load_i = 1'b1; opa_i = a; opb_i = b;
    @(negedge clk); load_i = 1'b0;
  endtask

  // Pulse start and return the number of negedges until done is seen
  task automatic run(output int lat);
    lat = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; lat = 1;
    while (!done_o && lat < 3 * W) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic add_case(input logic [W-1:0] a, input logic [W-1:0] b);
    int lat;
    int full;
    full = int'(a) + int'(b);
    do_load(a, b);
    chk("R1 load acc", int'(acc_o), int'(a));
    chk("R1 load addend", int'(opb_o), int'(b));
    chk("R1 load clears carry", int'(carry_o), 0);
    run(lat);
    chk("R6 latency", lat, W + 1);
    chk("R5 sum", int'(acc_o), full % (1 << W));
    chk("R5 carry out", int'(carry_o), full >> W);
    chk("R7 addend zero", int'(opb_o), 0);
    @(negedge clk);
    chk("R6 done single", int'(done_o), 0);
    @(negedge clk);
    chk("R6 hold idle", int'(acc_o), full % (1 << W));
  endtask

  initial begin
    int lat;
    logic [W-1:0] prev;
    logic         prevc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset acc", int'(acc_o), 0);
    chk("R1 reset carry", int'(carry_o), 0);
    chk("R2 reset busy", int'(busy_o), 0);
    cmp_on = 1;

    add_case(8'h5A, 8'h33);
    add_case(8'hFF, 8'h01);
    add_case(8'hFF, 8'hFF);
    add_case(8'h00, 8'h00);
    add_case(8'h80, 8'h80);
    add_case(8'h0F, 8'hF0);

    // R10: chain with retained carry (FF+01 leaves sum 0, carry 1, addend 0)
    add_case(8'hFF, 8'h01);
    prev = acc_o; prevc = carry_o;
    run(lat);
    chk("R10 chained sum", int'(acc_o), (int'(prev) + int'(prevc)) % (1 << W));
    chk("R10 chained carry", int'(carry_o), 0);

    // R8: load and start during a run are ignored
    do_load(8'hC3, 8'h5D);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); @(negedge clk);
    load_i = 1'b1; opa_i = 8'h11; opb_i = 8'h22; start_i = 1'b1;
    @(negedge clk); load_i = 1'b0; start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 3 * W) begin @(negedge clk); lat++; end
    chk("R8 sum unaffected", int'(acc_o), (8'hC3 + 8'h5D) % (1 << W));
    chk("R8 carry unaffected", int'(carry_o), (32'hC3 + 32'h5D) >> W);
    @(negedge clk);
    chk("R8 no restart", int'(busy_o), 0);

    // R9: load and start together
    @(negedge clk); load_i = 1'b1; start_i = 1'b1; opa_i = 8'h9C; opb_i = 8'h47;
    @(negedge clk); load_i = 1'b0; start_i = 1'b0;
    chk("R9 start ignored", int'(busy_o), 0);
    chk("R9 load taken", int'(acc_o), 32'h9C);
    @(negedge clk);
    chk("R9 still idle", int'(busy_o), 0);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule